// File: doc/BRIEF.md
# Asynchronous Static Memory Bus Timing Controller

This block turns single-word requests from inside the chip into bus cycles on an external asynchronous memory, such as NOR flash or SRAM. The bus does not share address and data lines. A requester raises `req` for one cycle while `busy` is low. The request carries a direction, a bank index, a byte address and, for a write, the data. The block then selects the addressed bank with its own active-low chip select and drives the address. It opens the read or write strobe for a programmed number of clock cycles and closes it again. When the access ends, it pulses `done`; for a read, `rdata` carries the captured word at that point.

Every access has four phases, each counted in clock cycles:
- an address setup phase before the strobe,
- a data phase while the strobe is active,
- an optional hold phase after the strobe,
- a turnaround gap before the next access can begin.

Reads and writes share one set of phase lengths unless split timing is switched on, in which case writes take their own set. The external word can be 16 bits or 8 bits wide. A slow device can stretch the data phase through a wait input, which can be gated off and whose active level is selectable. The block refuses a request to a disabled bank, and also refuses a write while writes are locked. It reports each refusal without touching the bus.

Top module: `sram_bus_timer`

## Requirements
- R1: After reset, all chip selects, `oeN` and `weN` are high, `memDoe`, `done`, `fault` and `busy` are low.
- R2: The addressed chip select is low for S cycles before the strobe opens, where S is the setup count of the timing set in use (0 allowed).
- R3: The strobe stays low for max(D,1) consecutive cycles, where D is the data count: `oeN` for reads, `weN` for writes, and never both at once.
- R4: The chip select stays low for H cycles after the strobe closes, where H is the hold count (0 allowed), and is high in every other cycle.
- R5: `done` is high for exactly the one cycle after the last chip-select-low cycle. `busy` stays high for T cycles starting with that cycle, where T is the turnaround count. A request is only taken while `busy` is low.
- R6: With `extMode`=0, both reads and writes use the rd* timing inputs. With `extMode`=1, writes use the wr* inputs and reads use rd*.
- R7: `bankSel` (binary 0..3) drives only `csN[bankSel]`. A request to a bank whose `bankEnable` bit is 0 gets no chip select and no strobe; `done` and `fault` then rise together in the cycle after the request.
- R8: While `writeAllow`=0, a write is refused exactly as in R7 and does not drive the bus. Reads proceed normally.
- R9: With `wideBus`=1, `memAddr` equals `addr` shifted right by one and all 16 data bits are used. With `wideBus`=0, `memAddr` equals `addr`, only bits 7:0 carry data, and bits 15:8 of `memDout` and `rdata` are zero.
- R10: A read captures `memDin` in the last cycle of the strobe. `rdata` shows the captured word from the `done` cycle until the next completed read; writes and refusals leave it unchanged.
- R11: With `waitUse`=1, each cycle in which `waitIn` equals `waitLevel` during the final data cycle adds one more strobe cycle. With `waitUse`=0, `waitIn` has no effect.
- R12: During a write, `memDoe` is high for every chip-select-low cycle, and `memDout` equals the write data (narrowed per R9). During a read, `memDoe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| req | input | 1 | One-cycle access request, taken while busy is low |
| we | input | 1 | 1 = write, 0 = read |
| bankSel | input | 2 | Bank index |
| addr | input | 20 | Internal byte address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Last read data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | With done: request refused |
| busy | output | 1 | Access or turnaround in progress |
| bankEnable | input | 4 | Per-bank enable |
| wideBus | input | 1 | 1 = 16-bit device, 0 = 8-bit device |
| extMode | input | 1 | Use separate write timing |
| writeAllow | input | 1 | Permit write accesses |
| waitUse | input | 1 | Honour waitIn |
| waitLevel | input | 1 | Active level of waitIn |
| rdSetup | input | 4 | Setup cycles, shared/read set |
| rdData | input | 4 | Data cycles, shared/read set |
| rdHold | input | 4 | Hold cycles, shared/read set |
| rdTurn | input | 4 | Turnaround cycles, shared/read set |
| wrSetup | input | 4 | Setup cycles, write set |
| wrData | input | 4 | Data cycles, write set |
| wrHold | input | 4 | Hold cycles, write set |
| wrTurn | input | 4 | Turnaround cycles, write set |
| csN | output | 4 | Active-low chip selects |
| memAddr | output | 20 | External address |
| memDout | output | 16 | Data driven to the device |
| memDoe | output | 1 | Output enable of the data pads |
| memDin | input | 16 | Data returned by the device |
| oeN | output | 1 | Active-low read strobe |
| weN | output | 1 | Active-low write strobe |
| waitIn | input | 1 | Wait request from the device |

## Verification
The bench sweeps every combination of zero and non-zero setup, data, hold and turnaround counts for both directions. An off-by-one in any phase counter therefore shows up as a wrong cycle count for chip select, strobe or `busy`. A zero-length phase handled wrongly would add or swallow a cycle. The read data the device model returns changes with each strobe cycle, so capturing one cycle early or late gives a wrong `rdata`. Further checks cover stretching by the wait input at both levels and a wait input that is present but gated off. They also cover refusals to disabled banks and locked writes, which must leave the bus and `rdata` untouched. Narrow-bus addressing and byte masking are checked, and so is split write timing, where a design that ignored `extMode` would give writes the read phase lengths.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  // Phases of one external access
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_DATA  = 3'd2,
    PH_HOLD  = 3'd3,
    PH_TURN  = 3'd4
  } phase_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic launch;     // request accepted this cycle: latch it
    logic active;     // chip select cycle (setup, data or hold)
    logic dataPhase;  // strobe cycle
    logic capture;    // last strobe cycle: sample read data
  } busCtl_t;

endpackage

// File: rtl/sbt_timing_sel.sv
module sbt_timing_sel #(
  parameter int TW = 4
) (
  input  logic          extMode,
  input  logic          isWrite,
  input  logic [TW-1:0] rdSetup,
  input  logic [TW-1:0] rdData,
  input  logic [TW-1:0] rdHold,
  input  logic [TW-1:0] rdTurn,
  input  logic [TW-1:0] wrSetup,
  input  logic [TW-1:0] wrData,
  input  logic [TW-1:0] wrHold,
  input  logic [TW-1:0] wrTurn,
  output logic [TW-1:0] selSetup,
  output logic [TW-1:0] selData,
  output logic [TW-1:0] selHold,
  output logic [TW-1:0] selTurn
);
  logic          useWr;
  logic [TW-1:0] rawData;

  assign useWr    = extMode && isWrite;
  assign selSetup = useWr ? wrSetup : rdSetup;
  assign rawData  = useWr ? wrData  : rdData;
  assign selHold  = useWr ? wrHold  : rdHold;
  assign selTurn  = useWr ? wrTurn  : rdTurn;
  // a strobe always lasts at least one cycle
  assign selData  = (rawData == '0) ? TW'(1) : rawData;
endmodule

// File: rtl/sbt_ctrl.sv
module sbt_ctrl
  import sbt_pkg::*;
#(
  parameter int TW = 4,
  parameter int NB = 4,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          req,
  input  logic          we,
  input  logic [BW-1:0] bankSel,
  input  logic [NB-1:0] bankEnable,
  input  logic          writeAllow,
  input  logic          waitUse,
  input  logic          waitLevel,
  input  logic          waitIn,
  input  logic [TW-1:0] selSetup,
  input  logic [TW-1:0] selData,
  input  logic [TW-1:0] selHold,
  input  logic [TW-1:0] selTurn,
  output busCtl_t       ctl,
  output logic          done,
  output logic          fault,
  output logic          busy
);
  phase_t        phase;
  logic [TW-1:0] cnt;
  logic [TW-1:0] tData, tHold, tTurn;
  logic          accept, reject, start, waitHit, lastData;

  assign accept   = req && (phase == PH_IDLE);
  assign reject   = accept && (!bankEnable[bankSel] || (we && !writeAllow));
  assign start    = accept && !reject;
  assign waitHit  = waitUse && (waitIn == waitLevel);
  assign lastData = (phase == PH_DATA) && (cnt == '0) && !waitHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      tData <= '0;
      tHold <= '0;
      tTurn <= '0;
      done  <= 1'b0;
      fault <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (reject) begin
            done  <= 1'b1;
            fault <= 1'b1;
          end else if (start) begin
            tData <= selData;
            tHold <= selHold;
            tTurn <= selTurn;
            if (selSetup != '0) begin
              phase <= PH_SETUP;
              cnt   <= selSetup - 1'b1;
            end else begin
              phase <= PH_DATA;
              cnt   <= selData - 1'b1;
            end
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            phase <= PH_DATA;
            cnt   <= tData - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_DATA: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (!waitHit) begin
            if (tHold != '0) begin
              phase <= PH_HOLD;
              cnt   <= tHold - 1'b1;
            end else begin
              done  <= 1'b1;
              phase <= (tTurn != '0) ? PH_TURN : PH_IDLE;
              cnt   <= tTurn - 1'b1;
            end
          end
        end
        PH_HOLD: begin
          if (cnt == '0) begin
            done  <= 1'b1;
            phase <= (tTurn != '0) ? PH_TURN : PH_IDLE;
            cnt   <= tTurn - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_TURN: begin
          if (cnt == '0) phase <= PH_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign ctl.launch    = start;
  assign ctl.active    = (phase == PH_SETUP) || (phase == PH_DATA) || (phase == PH_HOLD);
  assign ctl.dataPhase = (phase == PH_DATA);
  assign ctl.capture   = lastData;
  assign busy          = (phase != PH_IDLE);

  // R5
  done_after_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fault) |-> $past(phase == PH_DATA || phase == PH_HOLD));

  // R7
  refuse_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (done && $past(phase == PH_IDLE)));

  // R11
  wait_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(phase == PH_DATA && cnt == '0 && !waitUse)) |-> (phase != PH_DATA));
endmodule

// File: rtl/sbt_datapath.sv
module sbt_datapath
  import sbt_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int NB = 4,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1,
  localparam int HW = DW / 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  busCtl_t       ctl,
  input  logic          we,
  input  logic [BW-1:0] bankSel,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wideBus,
  input  logic [DW-1:0] memDin,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memDout,
  output logic          memDoe,
  output logic [NB-1:0] csN,
  output logic          oeN,
  output logic          weN,
  output logic [DW-1:0] rdata
);
  logic [AW-1:0] addrReg;
  logic [DW-1:0] wdataReg;
  logic [BW-1:0] bankReg;
  logic          weReg, wideReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      bankReg  <= '0;
      weReg    <= 1'b0;
      wideReg  <= 1'b0;
      rdata    <= '0;
    end else begin
      if (ctl.launch) begin
        addrReg  <= addr;
        wdataReg <= wdata;
        bankReg  <= bankSel;
        weReg    <= we;
        wideReg  <= wideBus;
      end
      if (ctl.capture && !weReg)
        rdata <= wideReg ? memDin : {{(DW-HW){1'b0}}, memDin[HW-1:0]};
    end
  end

  assign memAddr = wideReg ? (addrReg >> 1) : addrReg;
  assign memDout = wideReg ? wdataReg : {{(DW-HW){1'b0}}, wdataReg[HW-1:0]};
  assign memDoe  = ctl.active && weReg;
  assign oeN     = !(ctl.dataPhase && !weReg);
  assign weN     = !(ctl.dataPhase && weReg);

  for (genvar i = 0; i < NB; i++) begin : g_cs
    assign csN[i] = !(ctl.active && (bankReg == BW'(i)));
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!oeN && !weN));

  // R7
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  // R4
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!oeN || !weN) |-> (~csN != '0));

  // R12
  pad_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!weN |-> memDoe) and (!oeN |-> !memDoe));

  // R9
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.active && $past(ctl.active)) |-> $stable(memAddr));
endmodule

// File: rtl/sram_bus_timer.sv
module sram_bus_timer
  import sbt_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int TW = 4,
  parameter int NB = 4,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          req,
  input  logic          we,
  input  logic [BW-1:0] bankSel,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic          fault,
  output logic          busy,
  input  logic [NB-1:0] bankEnable,
  input  logic          wideBus,
  input  logic          extMode,
  input  logic          writeAllow,
  input  logic          waitUse,
  input  logic          waitLevel,
  input  logic [TW-1:0] rdSetup,
  input  logic [TW-1:0] rdData,
  input  logic [TW-1:0] rdHold,
  input  logic [TW-1:0] rdTurn,
  input  logic [TW-1:0] wrSetup,
  input  logic [TW-1:0] wrData,
  input  logic [TW-1:0] wrHold,
  input  logic [TW-1:0] wrTurn,
  output logic [NB-1:0] csN,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memDout,
  output logic          memDoe,
  input  logic [DW-1:0] memDin,
  output logic          oeN,
  output logic          weN,
  input  logic          waitIn
);
  busCtl_t       ctl;
  logic [TW-1:0] selSetup, selData, selHold, selTurn;

  sbt_timing_sel #(.TW(TW)) timing_i (
    .extMode(extMode), .isWrite(we),
    .rdSetup(rdSetup), .rdData(rdData), .rdHold(rdHold), .rdTurn(rdTurn),
    .wrSetup(wrSetup), .wrData(wrData), .wrHold(wrHold), .wrTurn(wrTurn),
    .selSetup(selSetup), .selData(selData), .selHold(selHold), .selTurn(selTurn)
  );

  sbt_ctrl #(.TW(TW), .NB(NB)) ctrl_i (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .bankSel(bankSel),
    .bankEnable(bankEnable), .writeAllow(writeAllow),
    .waitUse(waitUse), .waitLevel(waitLevel), .waitIn(waitIn),
    .selSetup(selSetup), .selData(selData), .selHold(selHold), .selTurn(selTurn),
    .ctl(ctl), .done(done), .fault(fault), .busy(busy)
  );

  sbt_datapath #(.AW(AW), .DW(DW), .NB(NB)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .we(we), .bankSel(bankSel),
    .addr(addr), .wdata(wdata), .wideBus(wideBus), .memDin(memDin),
    .memAddr(memAddr), .memDout(memDout), .memDoe(memDoe), .csN(csN),
    .oeN(oeN), .weN(weN), .rdata(rdata)
  );
endmodule

// File: tb/sram_bus_timer_tb_top.sv
module sram_bus_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  bankSel = '0;
  logic [19:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        done, fault, busy;
  logic [3:0]  bankEnable = 4'hF;
  logic        wideBus = 1'b1, extMode = 1'b0, writeAllow = 1'b1;
  logic        waitUse = 1'b0, waitLevel = 1'b0;
  logic [3:0]  rdSetup = '0, rdData = 4'd1, rdHold = '0, rdTurn = '0;
  logic [3:0]  wrSetup = '0, wrData = 4'd1, wrHold = '0, wrTurn = '0;
  logic [3:0]  csN;
  logic [19:0] memAddr;
  logic [15:0] memDout;
  logic        memDoe;
  logic [15:0] memDin = '0;
  logic        oeN, weN;
  logic        waitIn = 1'b1;

  int checks = 0, failures = 0;

  // per-access observations
  int actCnt, setCnt, rdCnt, wrCnt, holdCnt;
  logic [3:0]  csSeen;
  logic [19:0] wrAddrSeen;
  logic [15:0] wrDataSeen;
  bit doeBad;
  int waitFrom = 1, waitLeft = 0;
  bit forceWait = 0;

  always #2 clk = ~clk;

  sram_bus_timer dut_i (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .bankSel(bankSel), .addr(addr),
    .wdata(wdata), .rdata(rdata), .done(done), .fault(fault), .busy(busy),
    .bankEnable(bankEnable), .wideBus(wideBus), .extMode(extMode),
    .writeAllow(writeAllow), .waitUse(waitUse), .waitLevel(waitLevel),
    .rdSetup(rdSetup), .rdData(rdData), .rdHold(rdHold), .rdTurn(rdTurn),
    .wrSetup(wrSetup), .wrData(wrData), .wrHold(wrHold), .wrTurn(wrTurn),
    .csN(csN), .memAddr(memAddr), .memDout(memDout), .memDoe(memDoe),
    .memDin(memDin), .oeN(oeN), .weN(weN), .waitIn(waitIn)
  );

  // device model and bus monitor
  always @(negedge clk) begin
    if (rstN && (csN != 4'hF)) begin
      actCnt++;
      csSeen |= ~csN;
      if (!oeN) begin
        rdCnt++;
        memDin <= (memAddr[15:0] ^ 16'h3C5A) + 16'(rdCnt);
      end else if (!weN) begin
        wrCnt++;
        wrAddrSeen = memAddr;
        wrDataSeen = memDout;
      end else if (rdCnt + wrCnt == 0) setCnt++;
      else holdCnt++;
      if (memDoe !== we) doeBad = 1;
      if ((!oeN || !weN) && (rdCnt + wrCnt >= waitFrom) && waitLeft > 0) begin
        waitIn <= waitLevel;
        waitLeft--;
      end else waitIn <= forceWait ? waitLevel : !waitLevel;
    end else waitIn <= forceWait ? waitLevel : !waitLevel;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doAcc(input bit isWr, input int bank, input logic [19:0] a,
                       input logic [15:0] wd, input int eS, input int eD,
                       input int eH, input int eT, input bit expRej,
                       input int extra, input string tag);
    int n, tc, dEff;
    logic [19:0] ea;
    logic [15:0] er, prevR;
    dEff = (eD == 0) ? 1 : eD;
    actCnt = 0; setCnt = 0; rdCnt = 0; wrCnt = 0; holdCnt = 0;
    csSeen = '0; doeBad = 0; waitFrom = dEff; waitLeft = extra;
    prevR = rdata;
    req = 1; we = isWr; bankSel = 2'(bank); addr = a; wdata = wd;
    n = 0;
    @(negedge clk);
    req = 0;
    n = 1;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    ea = wideBus ? (a >> 1) : a;
    if (expRej) begin
      chk(n == 1 && fault, {tag, " R7/R8 refusal latency"}, n, 1);
      chk(actCnt == 0 && csSeen == 0, {tag, " R7/R8 no bus cycle"}, actCnt, 0);
      chk(rdata == prevR, {tag, " R10 rdata kept on refusal"}, rdata, prevR);
    end else begin
      chk(!fault, {tag, " R5 no fault"}, fault, 0);
      chk(n == eS + dEff + extra + eH + 1, {tag, " R5 done latency"}, n, eS + dEff + extra + eH + 1);
      chk(setCnt == eS, {tag, " R2 setup cycles"}, setCnt, eS);
      chk(holdCnt == eH, {tag, " R4 hold cycles"}, holdCnt, eH);
      chk(csSeen == (4'b1 << bank), {tag, " R7 chip select"}, csSeen, 4'b1 << bank);
      chk(!doeBad, {tag, " R12 pad enable"}, doeBad, 0);
      if (isWr) begin
        chk(wrCnt == dEff + extra && rdCnt == 0, {tag, " R3 write strobe"}, wrCnt, dEff + extra);
        chk(wrAddrSeen == ea, {tag, " R9 write address"}, wrAddrSeen, ea);
        er = wideBus ? wd : {8'h00, wd[7:0]};
        chk(wrDataSeen == er, {tag, " R12 write data"}, wrDataSeen, er);
        chk(rdata == prevR, {tag, " R10 rdata kept on write"}, rdata, prevR);
      end else begin
        chk(rdCnt == dEff + extra && wrCnt == 0, {tag, " R3 read strobe"}, rdCnt, dEff + extra);
        er = (ea[15:0] ^ 16'h3C5A) + 16'(dEff + extra);
        if (!wideBus) er = {8'h00, er[7:0]};
        chk(rdata == er, {tag, " R10 R9 read data"}, rdata, er);
      end
    end
    tc = 0;
    while (busy && tc < 100) begin
      tc++;
      @(negedge clk);
    end
    chk(tc == (expRej ? 0 : eT), {tag, " R5 turnaround"}, tc, expRej ? 0 : eT);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", wd);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] saved;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(csN == 4'hF && oeN && weN, "R1 strobes idle", {csN, oeN, weN}, 6'h3F);
    chk(!memDoe && !done && !fault && !busy, "R1 status idle", {memDoe, done, fault, busy}, 0);
    rstN = 1;
    @(negedge clk);
    chk(csN == 4'hF && !busy, "R1 after release", csN, 4'hF);

    // shared timing sweep, both directions (R2 R3 R4 R5 R6)
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 4; d++)
        for (int h = 0; h < 3; h++)
          for (int t = 0; t < 3; t++) begin
            rdSetup = 4'(s); rdData = 4'(d); rdHold = 4'(h); rdTurn = 4'(t);
            wrSetup = 4'd7; wrData = 4'd7; wrHold = 4'd7; wrTurn = 4'd7;
            doAcc(0, (s + t) % 4, 20'(24'h0ABC0 + s * 97 + d * 13 + h * 5 + t), 16'h0,
                  s, d, h, t, 0, 0, "sweep-rd");
            doAcc(1, (d + h) % 4, 20'(24'h51230 + s * 31 + d * 7 + h * 3 + t),
                  16'(16'hC000 + s * 256 + d * 16 + h * 4 + t), s, d, h, t, 0, 0, "sweep-wr R6");
          end

    // R6 split timing
    extMode = 1;
    rdSetup = 3; rdData = 1; rdHold = 0; rdTurn = 2;
    wrSetup = 1; wrData = 2; wrHold = 1; wrTurn = 1;
    doAcc(1, 1, 20'h00404, 16'h1234, 1, 2, 1, 1, 0, 0, "R6 split write");
    doAcc(0, 1, 20'h00406, 16'h0, 3, 1, 0, 2, 0, 0, "R6 split read");
    extMode = 0;
    rdSetup = 1; rdData = 2; rdHold = 1; rdTurn = 1;

    // R7 disabled bank
    bankEnable = 4'b1011;
    doAcc(0, 2, 20'h00100, 16'h0, 0, 0, 0, 0, 1, 0, "R7 disabled bank read");
    doAcc(1, 2, 20'h00100, 16'h55AA, 0, 0, 0, 0, 1, 0, "R7 disabled bank write");
    doAcc(0, 3, 20'h00102, 16'h0, 1, 2, 1, 1, 0, 0, "R7 enabled bank");
    bankEnable = 4'hF;

    // R8 write lock
    writeAllow = 0;
    doAcc(1, 0, 20'h00200, 16'hDEAD, 0, 0, 0, 0, 1, 0, "R8 locked write");
    doAcc(0, 0, 20'h00202, 16'h0, 1, 2, 1, 1, 0, 0, "R8 read while locked");
    writeAllow = 1;

    // R9 narrow bus
    wideBus = 0;
    doAcc(0, 1, 20'h12345, 16'h0, 1, 2, 1, 1, 0, 0, "R9 narrow read");
    doAcc(1, 1, 20'h12347, 16'hBEEF, 1, 2, 1, 1, 0, 0, "R9 narrow write");
    wideBus = 1;

    // R11 wait stretching, both levels, and gated off
    waitUse = 1; waitLevel = 0;
    doAcc(0, 0, 20'h03000, 16'h0, 1, 2, 1, 1, 0, 3, "R11 wait low read");
    waitLevel = 1;
    doAcc(1, 2, 20'h03010, 16'h7777, 1, 2, 1, 1, 0, 2, "R11 wait high write");
    waitUse = 0; forceWait = 1;
    doAcc(0, 3, 20'h03020, 16'h0, 1, 2, 1, 1, 0, 0, "R11 wait gated off");
    forceWait = 0;

    // R10 rdata holds across idle time
    saved = rdata;
    repeat (5) @(negedge clk);
    chk(rdata == saved, "R10 rdata held while idle", rdata, saved);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule